// File: doc/BRIEF.md
# Power-Up Reset Generator with Synchronized Release

This block gives a small programmable-logic design one clean internal reset, with or without an external reset pin. It relies on every flip-flop holding logic zero right after configuration. A short shift chain, whose first stage loads a constant one, therefore reads all zeros at power-up. It fills with ones over the first few clock edges, and that fill acts as an internal power-up reset. No device pin is needed for it.

An optional active-low external reset is merged with the internal one. When the external reset asserts, the output reset asserts at once, without waiting for a clock edge. When it releases, the release passes through a two-stage synchronizer. The output reset then falls on a single clock edge that every downstream register shares. One cycle after that edge, a one-cycle pulse marks the release.

A small demonstration state machine uses the synchronized reset. Its reset state is the all-zeros code, so the power-up value and the reset value are the same. Its first transition out of that state changes two state bits at once. This shows why a common release edge matters.

Top module: `rst_forge`

## Requirements
- R1: Before the first rising clock edge after power-up, `sysRst` is 1, `rstReleased` is 0 and `demoState` is 3'b000.
- R2: With `extRstN` held high from power-up, `sysRst` falls on the 5th rising edge. This is one edge more than the power-up chain depth of 4.
- R3: Once the power-up chain is full, `sysRst` falls on the 3rd rising edge after `extRstN` rises. This is one edge more than the synchronizer depth of 2.
- R4: While `extRstN` is 0, `sysRst` is 1 and `rstReleased` is 0, starting in the same time step as the falling input and without a clock edge.
- R5: `rstReleased` is 1 for exactly one cycle, starting on the rising edge after the edge on which `sysRst` fell. It is 0 at all other times.
- R6: `demoState` stays at 3'b000 on every edge where `sysRst` was 1 before that edge. On the first edge after the release with `demoGo` at 1, it moves from 3'b000 straight to 3'b011, with both low bits changing together.
- R7: Out of reset, on each edge with `demoGo` at 1, `demoState` steps 3'b011 -> 3'b110 -> 3'b101 -> 3'b011. With `demoGo` at 0 it holds.
- R8: Driving `extRstN` low at any later time returns `demoState` to 3'b000 on the next rising edge, without a power cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| extRstN | input | 1 | Optional external reset, active low, asynchronous |
| demoGo | input | 1 | Advance enable for the demonstration state machine |
| sysRst | output | 1 | Merged reset, active high; asserts asynchronously and releases synchronously |
| rstReleased | output | 1 | One-cycle pulse one edge after `sysRst` releases |
| demoState | output | 3 | State code of the demonstration state machine |

## Verification
Two events can land in the same cycle: the release pulse, and a new external reset assertion. The bench waits for the cycle in which `rstReleased` is high. It then pulls `extRstN` low at the falling clock edge. It expects `rstReleased` to drop and `sysRst` to rise before the next rising edge. A second collision is `demoGo` being high on the very edge where reset releases. The bench compares the whole state vector at that edge against 3'b011, so a partial move through 3'b001 or 3'b010 counts as a miscompare.

// File: rtl/rst_forge_pkg.sv
package rst_forge_pkg;

  // Strobes from the control (release sequencing) to the datapath.
  typedef struct packed {
    logic releaseOk;   // chain full and external release synchronized
    logic powerDone;   // internal power-up chain has filled
  } ctrlStrobes_t;

  // Demonstration machine; the reset state is the all-zeros code.
  typedef enum logic [2:0] {
    ST_IDLE = 3'b000,
    ST_LOAD = 3'b011,
    ST_RUN  = 3'b110,
    ST_DONE = 3'b101
  } demoState_t;

endpackage

// File: rtl/rst_forge_ctrl.sv
module rst_forge_ctrl
  import rst_forge_pkg::*;
#(
  parameter int CHAIN_DEPTH = 4,
  parameter int SYNC_DEPTH  = 2
) (
  input  logic         clk,
  input  logic         extClrN,
  output ctrlStrobes_t strobes
);

  localparam int CHAIN_TOP = CHAIN_DEPTH - 1;
  localparam int SYNC_TOP  = SYNC_DEPTH - 1;

  // Power-up chain: no reset at all. It relies on the all-zero configuration
  // value and loads a constant one at its head. The flow must be told to
  // preserve these flops, since their input is a constant.
  logic [CHAIN_DEPTH-1:0] powerChain = '0;
  // External release synchronizer: cleared at once, filled by the clock.
  logic [SYNC_DEPTH-1:0]  extSync    = '0;

  always_ff @(posedge clk) begin
    powerChain <= {powerChain[CHAIN_TOP-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge extClrN) begin
    if (!extClrN) extSync <= '0;
    else          extSync <= {extSync[SYNC_TOP-1:0], 1'b1};
  end

  always_comb begin
    strobes.powerDone = powerChain[CHAIN_TOP];
    strobes.releaseOk = powerChain[CHAIN_TOP] & extSync[SYNC_TOP];
  end

  // Once full, the power-up chain never empties again.
  assert_chain_sticky_R2: assert property (@(posedge clk) disable iff (!extClrN)
    powerChain[CHAIN_TOP] |=> powerChain[CHAIN_TOP]);

  // Release needs the synchronizer's last stage to have been set before.
  assert_sync_gate_R3: assert property (@(posedge clk) disable iff (!extClrN)
    !extSync[SYNC_TOP] |-> !strobes.releaseOk);

endmodule

// File: rtl/rst_forge_dp.sv
module rst_forge_dp
  import rst_forge_pkg::*;
(
  input  logic         clk,
  input  logic         extClrN,
  input  ctrlStrobes_t strobes,
  input  logic         demoGo,
  output logic         sysRst,
  output logic         rstReleased,
  output logic [2:0]   demoState
);

  // A single release flop feeds every consumer, so all of them share the edge.
  logic       releaseQ = 1'b0;
  logic       releaseD = 1'b0;
  logic       pulseQ   = 1'b0;
  demoState_t stateQ   = ST_IDLE;
  demoState_t stateNext;

  always_ff @(posedge clk or negedge extClrN) begin
    if (!extClrN) begin
      releaseQ <= 1'b0;
      releaseD <= 1'b0;
      pulseQ   <= 1'b0;
    end else begin
      releaseQ <= strobes.releaseOk;
      releaseD <= releaseQ;
      pulseQ   <= releaseQ & ~releaseD;
    end
  end

  always_comb begin
    stateNext = stateQ;
    if (demoGo) begin
      unique case (stateQ)
        ST_IDLE: stateNext = ST_LOAD;
        ST_LOAD: stateNext = ST_RUN;
        ST_RUN:  stateNext = ST_DONE;
        ST_DONE: stateNext = ST_LOAD;
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  // The state machine takes the released reset synchronously.
  always_ff @(posedge clk) begin
    if (!releaseQ) stateQ <= ST_IDLE;
    else           stateQ <= stateNext;
  end

  assign sysRst      = ~releaseQ;
  assign rstReleased = pulseQ;
  assign demoState   = stateQ;

  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!extClrN)
    pulseQ |=> !pulseQ);

  assert_pulse_follows_R5: assert property (@(posedge clk) disable iff (!extClrN)
    $rose(releaseQ) |=> pulseQ);

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!extClrN)
    !releaseQ |=> (stateQ == ST_IDLE));

  assert_idle_exit_R6: assert property (@(posedge clk) disable iff (!extClrN)
    (stateQ == ST_IDLE) |=> (stateQ == ST_IDLE || stateQ == ST_LOAD));

  assert_power_gate_R2: assert property (@(posedge clk) disable iff (!extClrN)
    $rose(releaseQ) |-> $past(strobes.powerDone));

endmodule

// File: rtl/rst_forge.sv
module rst_forge
  import rst_forge_pkg::*;
#(
  parameter int CHAIN_DEPTH = 4,
  parameter int SYNC_DEPTH  = 2,
  parameter bit USE_EXT_RST = 1'b1
) (
  input  logic       clk,
  input  logic       extRstN,
  input  logic       demoGo,
  output logic       sysRst,
  output logic       rstReleased,
  output logic [2:0] demoState
);

  logic         extClrN;
  ctrlStrobes_t strobes;

  generate
    if (USE_EXT_RST) begin : gExtUsed
      assign extClrN = extRstN;
    end else begin : gExtTied
      assign extClrN = 1'b1;
    end
  endgenerate

  rst_forge_ctrl #(
    .CHAIN_DEPTH(CHAIN_DEPTH),
    .SYNC_DEPTH (SYNC_DEPTH)
  ) uCtrl (
    .clk    (clk),
    .extClrN(extClrN),
    .strobes(strobes)
  );

  rst_forge_dp uDp (
    .clk        (clk),
    .extClrN    (extClrN),
    .strobes    (strobes),
    .demoGo     (demoGo),
    .sysRst     (sysRst),
    .rstReleased(rstReleased),
    .demoState  (demoState)
  );

endmodule

// File: tb/rst_forge_test.sv
module rst_forge_test;

  localparam int CLK_PERIOD = 10;
  localparam int CHAIN      = 4;
  localparam int SYNC       = 2;

  logic       clk = 1'b0;
  logic       extRstN = 1'b1;
  logic       demoGo = 1'b0;
  logic       sysRst, rstReleased;
  logic [2:0] demoState;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Model state, derived from the requirement timings.
  int       pwrEdges = 0;
  int       relEdges = 0;
  bit       expRel = 1'b0, expRelD = 1'b0, expPulse = 1'b0;
  logic [2:0] expState = 3'b000;
  logic [2:0] prevExpState = 3'b000;

  rst_forge uut (
    .clk(clk), .extRstN(extRstN), .demoGo(demoGo),
    .sysRst(sysRst), .rstReleased(rstReleased), .demoState(demoState)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [2:0] nextDemo(input logic [2:0] s, input bit go);
    if (!go) return s;
    case (s)
      3'b000:  return 3'b011;
      3'b011:  return 3'b110;
      3'b110:  return 3'b101;
      3'b101:  return 3'b011;
      default: return 3'b000;
    endcase
  endfunction

  always @(posedge clk) begin
    bit newRel;
    newRel = extRstN && (pwrEdges >= CHAIN) && (relEdges >= SYNC);
    prevExpState = expState;
    expState = expRel ? nextDemo(expState, demoGo) : 3'b000;
    expPulse = extRstN && expRel && !expRelD;
    expRelD  = extRstN && expRel;
    expRel   = newRel;
    if (pwrEdges < 1000) pwrEdges++;
    if (extRstN && relEdges < 1000) relEdges++;
  end

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  task automatic driveExt(input bit v);
    extRstN = v;
    if (!v) begin
      relEdges = 0;
      expRel = 1'b0; expRelD = 1'b0; expPulse = 1'b0;
    end
  endtask

  // One cycle: drive at the falling edge, compare shortly after.
  task automatic cycle(input bit ext, input bit go);
    @(negedge clk);
    driveExt(ext);
    demoGo = go;
    #1;
    check(!extRstN ? "R4 sysRst" : (pwrEdges <= CHAIN + 1 ? "R2 sysRst" : "R3 sysRst"),
          {2'b0, sysRst}, {2'b0, !expRel});
    check(!extRstN ? "R4 rstReleased" : "R5 rstReleased",
          {2'b0, rstReleased}, {2'b0, expPulse});
    check(!extRstN ? "R8 demoState" :
          (prevExpState == 3'b000 ? "R6 demoState" : "R7 demoState"),
          demoState, expState);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd424242);
    #1;
    // R1: power-up values before any clock edge.
    check("R1 sysRst", {2'b0, sysRst}, 3'b001);
    check("R1 rstReleased", {2'b0, rstReleased}, 3'b000);
    check("R1 demoState", demoState, 3'b000);

    // R2, R6: internal power-up only, demoGo high through the release edge.
    for (int i = 0; i < 10; i++) cycle(1'b1, 1'b1);

    // R8, R3: re-assert, then release; collide the pulse with a new assertion.
    cycle(1'b0, 1'b1);
    cycle(1'b0, 1'b0);
    while (!expPulse) cycle(1'b1, 1'b1);
    cycle(1'b0, 1'b1);          // external reset lands on the pulse cycle
    for (int i = 0; i < 8; i++) cycle(1'b1, 1'b0);
    for (int i = 0; i < 6; i++) cycle(1'b1, 1'b1);

    // Random mix of holds, steps and external resets.
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 25) == 0) begin
        int len;
        len = 1 + ($urandom % 3);
        for (int k = 0; k < len; k++) cycle(1'b0, 1'($urandom % 2));
      end else begin
        cycle(1'b1, ($urandom % 4) != 0);
      end
    end
    finishRun();
  end

endmodule